// File: doc/BRIEF.md
# Asymmetric Micro-op Decoder

This block turns a group of up to three already-delimited instruction descriptors into three-operand micro-ops (two source registers and one destination register). The descriptors arrive oldest first. The block has three decode slots. Slot 0 is the complex slot and can expand one instruction into as many as four micro-ops. Slots 1 and 2 are simple slots and each produces exactly one micro-op. At full occupancy the block emits six micro-ops per cycle.

An instruction that needs more than four micro-ops is not decoded by a slot. It is passed to a sequencer stub. The stub is a down-counter that emits one micro-op per output cycle until the instruction is finished, and it holds all new decoding while it runs. The upstream stage presents a window of descriptors. Each cycle the block reports how many it consumed, so the window can shift by that number.

Outputs are registered and use a ready handshake. When the consumer stalls, everything freezes: the outputs hold their values and no input is consumed.

Top module: `mop_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is all zero and `in_take` is zero.
- R2: Every emitted micro-op copies kind, ra, rb and rd from its descriptor, and its idx field numbers it 0..n-1 within its instruction. The micro-op layout is kind [1:0], idx [5:2], ra [8:6], rb [11:9], rd [14:12]. The descriptor uses the same positions, with the micro-op count in bits [5:2].
- R3: The micro-op count of an instruction depends on its kind. A load (kind 1) needs 1 micro-op and a store (kind 2) needs 2, whatever the count field holds. An alu (kind 0) or misc (kind 3) instruction needs the number in its count field, and a count field of 0 means 1.
- R4: The oldest descriptor in the window always goes to slot 0. If it needs n ≤ 4 micro-ops, they appear on lanes 0..n-1 in the next output cycle.
- R5: Descriptor j (j = 1, 2) goes to simple slot j, shown on lane 3+j, only if every older descriptor in the window was taken and descriptor j needs exactly one micro-op. The first descriptor that fails this test, and every descriptor after it, waits for a later cycle. `in_take` reports how many descriptors were taken.
- R6: A window of a four-micro-op instruction followed by two one-micro-op instructions fills all six lanes in one output cycle.
- R7: An oldest descriptor needing more than four micro-ops is taken alone. Its micro-ops then appear one per output cycle on lane 0, with idx 0..n-1. `in_take` stays zero until the last of them has been loaded into the output register.
- R8: While any lane is valid and `out_ready` is low, `out_valid` and `out_uop` keep their values and `in_take` is zero.
- R9: The valid lanes of slot 0 are always contiguous from lane 0. A simple lane is valid only if lane 0 and every lower simple lane are valid.
- R10: `in_take` never exceeds `in_num`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_num | input | 2 | Number of valid descriptors in the window (0..3) |
| in_desc | input | 45 | Three 15-bit descriptors; descriptor 0 (oldest) in bits [14:0] |
| in_take | output | 2 | Descriptors consumed this cycle |
| out_ready | input | 1 | Consumer accepts the current output group |
| out_valid | output | 6 | Lane valids; lanes 0..3 belong to the complex slot, lanes 4 and 5 to the simple slots |
| out_uop | output | 90 | Six 15-bit micro-ops; lane 0 in bits [14:0] |

## Verification
A behavioural queue model predicts the lanes and the take count on every cycle. The stimulus runs in directed phases. Load, store and zero-count descriptors show whether the kind overrides the count field. Mixed counts of 1 to 4 show where a group gets cut at a multi-micro-op younger descriptor. Repeated 4+1+1 windows are the only pattern that can reach the six-lane peak. Long instructions placed between short ones separate sequencer stalling from normal steering. A final random phase with a toggling ready line shows whether the output is held and nothing is consumed under backpressure.

// File: rtl/mop_pkg.sv
package mop_pkg;

    localparam int RW = 3;   // register specifier width
    localparam int CW = 4;   // micro-op count / index width

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_MISC  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [RW-1:0] rd;
        logic [RW-1:0] rb;
        logic [RW-1:0] ra;
        logic [CW-1:0] cnt;
        kind_e         kind;
    } desc_t;

    typedef struct packed {
        logic [RW-1:0] rd;
        logic [RW-1:0] rb;
        logic [RW-1:0] ra;
        logic [CW-1:0] idx;
        kind_e         kind;
    } uop_t;

    localparam int DESC_W = $bits(desc_t);
    localparam int UOP_W  = $bits(uop_t);

    // micro-ops an instruction really needs
    function automatic logic [CW-1:0] eff_count(desc_t d);
        logic [CW-1:0] n;
        case (d.kind)
            K_LOAD:  n = CW'(1);
            K_STORE: n = CW'(2);
            default: n = (d.cnt == '0) ? CW'(1) : d.cnt;
        endcase
        return n;
    endfunction

    function automatic uop_t make_uop(desc_t d, logic [CW-1:0] i);
        uop_t u;
        u.kind = d.kind;
        u.idx  = i;
        u.ra   = d.ra;
        u.rb   = d.rb;
        u.rd   = d.rd;
        return u;
    endfunction

endpackage

// File: rtl/mop_steer.sv
module mop_steer
    import mop_pkg::*;
#(
    parameter int N_SIMPLE  = 2,
    parameter int CPLX_UOPS = 4,
    localparam int GROUP    = N_SIMPLE + 1,
    localparam int NUMW     = $clog2(GROUP + 1)
) (
    input  logic [NUMW-1:0]        num,
    input  desc_t [GROUP-1:0]      desc,
    output logic [GROUP-1:0]       slot_en,
    output logic                   long0,
    output logic [NUMW-1:0]        take
);

    always_comb begin
        slot_en = '0;
        long0   = 1'b0;
        take    = '0;
        if (num != '0) begin
            slot_en[0] = 1'b1;
            take       = NUMW'(1);
            if (eff_count(desc[0]) > CW'(CPLX_UOPS)) begin
                long0 = 1'b1;
            end else begin
                for (int j = 1; j < GROUP; j++) begin
                    if ((NUMW'(j) < num) && (take == NUMW'(j)) &&
                        (eff_count(desc[j]) == CW'(1))) begin
                        slot_en[j] = 1'b1;
                        take       = take + NUMW'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mop_expand.sv
module mop_expand
    import mop_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic               en,
    input  desc_t              desc,
    output logic [N_OUT-1:0]   lane_v,
    output uop_t [N_OUT-1:0]   lane_u
);

    logic [CW-1:0] n_uops;
    assign n_uops = eff_count(desc);

    for (genvar k = 0; k < N_OUT; k++) begin : g_lane
        assign lane_v[k] = en && (CW'(k) < n_uops);
        assign lane_u[k] = make_uop(desc, CW'(k));
    end

endmodule

// File: rtl/mop_decoder.sv
module mop_decoder
    import mop_pkg::*;
#(
    parameter int N_SIMPLE  = 2,
    parameter int CPLX_UOPS = 4,
    localparam int GROUP    = N_SIMPLE + 1,
    localparam int LANES    = CPLX_UOPS + N_SIMPLE,
    localparam int NUMW     = $clog2(GROUP + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUMW-1:0]          in_num,
    input  logic [GROUP*DESC_W-1:0]  in_desc,
    output logic [NUMW-1:0]          in_take,
    input  logic                     out_ready,
    output logic [LANES-1:0]         out_valid,
    output logic [LANES*UOP_W-1:0]   out_uop
);

    typedef struct packed {
        logic [LANES-1:0]  v;
        uop_t [LANES-1:0]  u;
        logic [CW-1:0]     left;   // sequencer micro-ops still to emit
        logic [CW-1:0]     idx;    // next sequencer micro-op index
        desc_t             sd;     // instruction held by the sequencer
    } st_t;

    st_t st_q, st_d;

    desc_t [GROUP-1:0] desc;
    assign desc = in_desc;

    logic [GROUP-1:0] slot_en;
    logic             long0;
    logic [NUMW-1:0]  take;

    mop_steer #(
        .N_SIMPLE  (N_SIMPLE),
        .CPLX_UOPS (CPLX_UOPS)
    ) u_steer (
        .num     (in_num),
        .desc    (desc),
        .slot_en (slot_en),
        .long0   (long0),
        .take    (take)
    );

    logic [CPLX_UOPS-1:0] cplx_v;
    uop_t [CPLX_UOPS-1:0] cplx_u;
    logic [N_SIMPLE-1:0]  simp_v;
    uop_t [N_SIMPLE-1:0]  simp_u;

    mop_expand #(.N_OUT(CPLX_UOPS)) u_cplx (
        .en     (slot_en[0]),
        .desc   (desc[0]),
        .lane_v (cplx_v),
        .lane_u (cplx_u)
    );

    for (genvar s = 1; s < GROUP; s++) begin : g_simple
        mop_expand #(.N_OUT(1)) u_simple (
            .en     (slot_en[s]),
            .desc   (desc[s]),
            .lane_v (simp_v[s-1]),
            .lane_u (simp_u[s-1])
        );
    end

    logic adv;
    logic seq_busy;
    assign adv      = ~(|st_q.v) | out_ready;
    assign seq_busy = (st_q.left != '0);

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.v = '0;
            st_d.u = '0;
            if (seq_busy) begin
                st_d.v[0] = 1'b1;
                st_d.u[0] = make_uop(st_q.sd, st_q.idx);
                st_d.left = st_q.left - CW'(1);
                st_d.idx  = st_q.idx + CW'(1);
            end else if (long0) begin
                st_d.v[0] = 1'b1;
                st_d.u[0] = make_uop(desc[0], '0);
                st_d.left = eff_count(desc[0]) - CW'(1);
                st_d.idx  = CW'(1);
                st_d.sd   = desc[0];
            end else begin
                st_d.v = {simp_v, cplx_v};
                st_d.u = {simp_u, cplx_u};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_take   = (rst_n && adv && !seq_busy) ? take : '0;
    assign out_valid = st_q.v;
    assign out_uop   = st_q.u;

endmodule

// File: rtl/mop_decoder_chk.sv
module mop_decoder_chk
    import mop_pkg::*;
#(
    parameter int N_SIMPLE  = 2,
    parameter int CPLX_UOPS = 4,
    localparam int GROUP    = N_SIMPLE + 1,
    localparam int LANES    = CPLX_UOPS + N_SIMPLE,
    localparam int NUMW     = $clog2(GROUP + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUMW-1:0]         in_num,
    input logic [NUMW-1:0]         in_take,
    input logic                    out_ready,
    input logic [LANES-1:0]        out_valid,
    input logic [LANES*UOP_W-1:0]  out_uop,
    input logic                    seq_busy
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid && !out_ready) |=> ($stable(out_valid) && $stable(out_uop)));

    // R8
    hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid && !out_ready) |-> (in_take == '0));

    // R10
    take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_take <= in_num);

    // R7
    seq_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (in_take == '0));

    // R7
    seq_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> ($countones(out_valid) <= 1));

    for (genvar k = 1; k < LANES; k++) begin : g_contig
        localparam int PREV = (k == CPLX_UOPS) ? 0 : k - 1;
        // R9
        lane_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> out_valid[PREV]);
    end

endmodule

bind mop_decoder mop_decoder_chk #(
    .N_SIMPLE  (N_SIMPLE),
    .CPLX_UOPS (CPLX_UOPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_num    (in_num),
    .in_take   (in_take),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_uop   (out_uop),
    .seq_busy  (st_q.left != '0)
);

// File: tb/tb_mop_decoder.sv
`timescale 1ns/1ps
module tb_mop_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_num = '0;
    logic [44:0] in_desc = '0;
    logic [1:0]  in_take;
    logic        out_ready = 1'b1;
    logic [5:0]  out_valid;
    logic [89:0] out_uop;

    always #2.5 clk = ~clk;

    mop_decoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_num    (in_num),
        .in_desc   (in_desc),
        .in_take   (in_take),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_uop   (out_uop)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit timeout = 0;

    logic [14:0] iq[$];
    int          head = 0;

    // model state
    bit   [5:0]  ev = '0;
    logic [14:0] eu [6];
    int          sl = 0;
    int          si = 0;
    logic [14:0] sd = '0;

    string ptag = "R4";
    int    rmode = 0;
    int    peak_seen = 0;

    function automatic logic [14:0] mkd(int kind, int cnt, int ra, int rb, int rd);
        return {3'(rd), 3'(rb), 3'(ra), 4'(cnt), 2'(kind)};
    endfunction

    function automatic int eff(logic [14:0] d);
        int k = int'(d[1:0]);
        int c = int'(d[5:2]);
        if (k == 1) return 1;
        if (k == 2) return 2;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic logic [14:0] uop_of(logic [14:0] d, int i);
        return {d[14:6], 4'(i), d[1:0]};
    endfunction

    task automatic fail(string tag, string what, longint act, longint exp);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    task automatic step();
        int n;
        int etake;
        bit adv;
        bit [5:0] nv;
        logic [14:0] nu [6];
        @(negedge clk);
        cyc++;
        if (cyc > 100000) begin
            timeout = 1;
            return;
        end
        // compare registered outputs against model
        n_chk++;
        if (out_valid != ev) fail({ptag, " R9"}, "lane valids", out_valid, ev);
        n_chk++;
        begin
            bit bad = 0;
            for (int k = 0; k < 6; k++)
                if (ev[k] && out_uop[k*15 +: 15] !== eu[k]) begin
                    bad = 1;
                    fail("R2", $sformatf("lane %0d uop", k), out_uop[k*15 +: 15], eu[k]);
                end
        end
        if (ptag == "R6" && out_valid == 6'h3f) peak_seen++;
        // drive next window
        n = iq.size() - head;
        if (n > 3) n = 3;
        in_num = 2'(n);
        for (int j = 0; j < 3; j++)
            in_desc[j*15 +: 15] = (j < n) ? iq[head+j] : 15'h0;
        out_ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
        #1;
        // model next
        adv = (ev == 0) || out_ready;
        etake = 0;
        nv = ev;
        for (int k = 0; k < 6; k++) nu[k] = eu[k];
        if (adv) begin
            nv = '0;
            if (sl > 0) begin
                nv[0] = 1; nu[0] = uop_of(sd, si);
                si++; sl--;
            end else if (n > 0) begin
                int e0 = eff(iq[head]);
                etake = 1;
                if (e0 > 4) begin
                    nv[0] = 1; nu[0] = uop_of(iq[head], 0);
                    sd = iq[head]; sl = e0 - 1; si = 1;
                end else begin
                    for (int k = 0; k < e0; k++) begin
                        nv[k] = 1; nu[k] = uop_of(iq[head], k);
                    end
                    for (int j = 1; j < 3; j++)
                        if (j < n && etake == j && eff(iq[head+j]) == 1) begin
                            nv[3+j] = 1; nu[3+j] = uop_of(iq[head+j], 0);
                            etake++;
                        end
                end
            end
        end
        n_chk++;
        if (int'(in_take) != etake) begin
            string t = (!adv) ? "R8" : (sl > 0 && etake == 0) ? "R7" : "R5/R10";
            fail(t, "in_take", in_take, etake);
        end
        @(posedge clk);
        ev = nv;
        for (int k = 0; k < 6; k++) eu[k] = nu[k];
        head += etake;
    endtask

    task automatic drain();
        while (!timeout && (head < iq.size() || ev != 0 || sl != 0)) step();
        if (!timeout) step();
    endtask

    initial begin
        for (int k = 0; k < 6; k++) eu[k] = '0;
        // R1: reset state with a full window presented
        in_num = 2'd3;
        in_desc = {mkd(0,1,1,2,3), mkd(0,1,4,5,6), mkd(0,3,7,1,2)};
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid != 0) fail("R1", "valid in reset", out_valid, 0);
        n_chk++;
        if (in_take != 0) fail("R1", "take in reset", in_take, 0);
        in_num = '0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid != 0) fail("R1", "valid after reset", out_valid, 0);

        // R3: kind overrides count field, zero count means one
        ptag = "R3";
        iq.push_back(mkd(1, 9, 1, 2, 3));   // load, 1 uop
        iq.push_back(mkd(2, 0, 2, 3, 4));   // store, 2 uops
        iq.push_back(mkd(0, 0, 3, 4, 5));   // alu zero count, 1 uop
        iq.push_back(mkd(3, 3, 4, 5, 6));   // misc, 3 uops
        iq.push_back(mkd(1, 15, 5, 6, 7));  // load with large field
        iq.push_back(mkd(2, 1, 6, 7, 0));   // store with count 1
        drain();

        // R4 / R5: mixed counts 1..4 cut groups at younger multi-uop
        ptag = "R4";
        for (int i = 0; i < 40; i++)
            iq.push_back(mkd(((i % 5) == 3) ? 3 : 0, 1 + (i * 7 % 4), i % 8, (i + 3) % 8, (i + 5) % 8));
        drain();

        // R6: 4+1+1 windows fill all lanes
        ptag = "R6";
        for (int i = 0; i < 8; i++) begin
            iq.push_back(mkd(3, 4, i % 8, 1, 2));
            iq.push_back(mkd(0, 1, 3, i % 8, 4));
            iq.push_back(mkd(1, 0, 5, 6, i % 8));
        end
        drain();
        n_chk++;
        if (peak_seen == 0) fail("R6", "six-lane cycles", peak_seen, 8);

        // R7: long instructions go through the sequencer
        ptag = "R7";
        iq.push_back(mkd(0, 1, 1, 1, 1));
        iq.push_back(mkd(3, 5, 2, 3, 4));
        iq.push_back(mkd(0, 1, 5, 6, 7));
        iq.push_back(mkd(3, 15, 7, 0, 1));
        iq.push_back(mkd(3, 12, 2, 2, 2));
        iq.push_back(mkd(2, 7, 3, 3, 3));
        iq.push_back(mkd(3, 4, 4, 4, 4));
        drain();

        // R8: random traffic with backpressure
        ptag = "R8";
        rmode = 1;
        for (int i = 0; i < 300; i++) begin
            int r = $urandom % 10;
            int c = (r < 5) ? 1 : (r < 8) ? 2 + ($urandom % 3) : 5 + ($urandom % 11);
            iq.push_back(mkd($urandom % 4, c, $urandom % 8, $urandom % 8, $urandom % 8));
        end
        drain();

        if (timeout) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule